// File: doc/BRIEF.md
# Machine Cycle Timing and Event Recorder

This block follows the machine cycles of an accelerator and records where each cycle's acquisition data is stored. A strobe on the cycle-start line adds one to a cycle counter and clears a millisecond clock, which then counts the 1 ms ticks. On each tick the block writes one word into an on-chip timing table. The word pairs the current cycle number with the write address of the external data store at that moment. Software can later use this table to find the data for a given cycle and time.

Every clock in which one or more timing strobes are high produces one entry in a small event table. The entry holds a code that names the strobes and a pointer into the timing table. The event table has a region for each of the last four cycles, with sixteen slots per region. The regions are selected by the low two bits of the cycle number, so a fifth cycle writes over the region of the first.

The outputs are registered write ports for the two tables, plus the cycle number, the millisecond time and the address of the last timing-table write.

Top module: `cycle_event_recorder`

## Requirements
- R1: While reset is held and in the first clock after it, every output is zero and neither table receives a write.
- R2: Each clock with the cycle-start strobe (evt_strobe bit 0) high raises cycle_num by one. The new value is visible after that clock edge.
- R3: ms_time rises by one for each clock with ms_tick high. In a clock where the cycle-start strobe is high it becomes 0, even if ms_tick is high in that same clock.
- R4: Each clock with ms_tick high produces exactly one timing-table write in the next cycle. Bits 63:32 of tt_wdata hold the data_wr_addr sampled with the tick. Bits 31:0 hold the cycle number after that clock's update.
- R5: The timing-table write address begins at 0 and steps by one per write. After address 4095 it returns to 0.
- R6: tt_last_addr shows the address of the most recent timing-table write.
- R7: Each logged event entry carries a code in bits 31:24. The code is evt_strobe zero-extended, with bit 0 for cycle start, bit 1 for cycle stop, bit 2 for calibration start, bit 3 for calibration stop, bit 4 for injection and bit 5 for harmonic change. Bits 23:0 hold the timing-table address that the next timing write will use, sampled before that clock's tick takes effect. Several strobes in one clock give a single entry.
- R8: The event-table address is {cycle_num[1:0], slot[3:0]}, using the cycle number after that clock's update. A clock with cycle start always writes slot 0.
- R9: Within a cycle each logged entry moves the slot up by one. After slot 15 has been written, further events without cycle start are dropped and produce no write until the next cycle start.
- R10: The fifth cycle after a start reuses the event-table region of the first, so the table holds the last four cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 6 | Timing event strobes; bit meanings given in R7 |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| data_wr_addr | input | 32 | Current write address of the data store |
| tt_we | output | 1 | Timing-table write enable |
| tt_waddr | output | 12 | Timing-table write address |
| tt_wdata | output | 64 | Timing-table write word |
| ev_we | output | 1 | Event-table write enable |
| ev_waddr | output | 6 | Event-table write address |
| ev_wdata | output | 32 | Event-table write word |
| cycle_num | output | 32 | Cycle counter |
| ms_time | output | 32 | Milliseconds since the last cycle start |
| tt_last_addr | output | 12 | Address of the last timing-table write |

## Verification
The bench sends a cycle start and a tick in the same clock. A design with the wrong priority would keep counting milliseconds, or would write the old cycle number into the timing word. It sends more than sixteen events in one cycle. A design that let the slot counter wrap would overwrite slot 0 of the live cycle instead of dropping the extra events. It runs five cycles to show that the event regions are reused, and it runs more than 4096 ticks. A design with a wrong wrap limit would run its timing address past the table or jump back early. It also checks that the event pointer is the timing address before the tick, since an off-by-one pointer would make every event reference the wrong timing entry.

// File: rtl/cer_pkg.sv
package cer_pkg;
    localparam int N_EVT  = 6;
    localparam int CODE_W = 8;
    // Positions of the strobes in the event vector and in the event code
    localparam int B_CYC_START = 0;
    localparam int B_CYC_STOP  = 1;
    localparam int B_CAL_START = 2;
    localparam int B_CAL_STOP  = 3;
    localparam int B_INJECT    = 4;
    localparam int B_HARM      = 5;
endpackage

// File: rtl/cer_cycle_clock.sv
module cer_cycle_clock #(
    parameter int CYC_W  = 32,
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    output logic [CYC_W-1:0]  cycle_next,
    output logic [CYC_W-1:0]  cycle_q,
    output logic [TIME_W-1:0] ms_q
);
    typedef struct packed {
        logic [CYC_W-1:0]  cycle;
        logic [TIME_W-1:0] ms;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cycle = st_q.cycle + 1'b1;
            st_d.ms    = '0;
        end else if (tick) begin
            st_d.ms    = st_q.ms + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cycle_next = st_d.cycle;
    assign cycle_q    = st_q.cycle;
    assign ms_q       = st_q.ms;

    p_cycle_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cycle_q == $past(cycle_q) + 1'b1);
    p_ms_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ms_q == '0);
    p_ms_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !tick) |=> $stable(ms_q));
endmodule

// File: rtl/cer_timing_writer.sv
module cer_timing_writer #(
    parameter int CYC_W    = 32,
    parameter int ADDR_W   = 32,
    parameter int TT_DEPTH = 4096,
    localparam int TT_AW   = $clog2(TT_DEPTH),
    localparam int TT_DW   = ADDR_W + CYC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic [CYC_W-1:0]  cycle_next,
    output logic [TT_AW-1:0]  ptr_q,
    output logic              we,
    output logic [TT_AW-1:0]  waddr,
    output logic [TT_DW-1:0]  wdata,
    output logic [TT_AW-1:0]  last
);
    localparam logic [TT_AW-1:0] TOP = TT_AW'(TT_DEPTH - 1);

    typedef struct packed {
        logic             we;
        logic [TT_AW-1:0] waddr;
        logic [TT_DW-1:0] wdata;
        logic [TT_AW-1:0] ptr;
        logic [TT_AW-1:0] last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.we = tick;
        if (tick) begin
            st_d.waddr = st_q.ptr;
            st_d.wdata = {data_addr, cycle_next};
            st_d.last  = st_q.ptr;
            st_d.ptr   = (st_q.ptr == TOP) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q = st_q.ptr;
    assign we    = st_q.we;
    assign waddr = st_q.waddr;
    assign wdata = st_q.wdata;
    assign last  = st_q.last;

    p_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> we && waddr == $past(ptr_q));
    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !we);
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ptr_q == TOP) |=> ptr_q == '0);
endmodule

// File: rtl/cer_event_logger.sv
module cer_event_logger #(
    parameter int N_EVT     = 6,
    parameter int CODE_W    = 8,
    parameter int PTR_W     = 24,
    parameter int TT_AW     = 12,
    parameter int EV_CYCLES = 4,
    parameter int EV_SLOTS  = 16,
    localparam int EV_CW    = $clog2(EV_CYCLES),
    localparam int EV_SW    = $clog2(EV_SLOTS),
    localparam int EV_AW    = EV_CW + EV_SW,
    localparam int EV_DW    = CODE_W + PTR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] strobe,
    input  logic             start,
    input  logic [EV_CW-1:0] cyc_lo,
    input  logic [TT_AW-1:0] tt_ptr,
    output logic             we,
    output logic [EV_AW-1:0] waddr,
    output logic [EV_DW-1:0] wdata
);
    localparam logic [EV_SW:0] FULL = (EV_SW+1)'(EV_SLOTS);

    typedef struct packed {
        logic             we;
        logic [EV_AW-1:0] waddr;
        logic [EV_DW-1:0] wdata;
        logic [EV_SW:0]   slot;
    } st_t;

    st_t st_d, st_q;
    logic [EV_DW-1:0] entry;

    assign entry = {CODE_W'(strobe), PTR_W'(tt_ptr)};

    always_comb begin
        st_d    = st_q;
        st_d.we = 1'b0;
        if (start) begin
            st_d.we    = 1'b1;
            st_d.waddr = {cyc_lo, {EV_SW{1'b0}}};
            st_d.wdata = entry;
            st_d.slot  = (EV_SW+1)'(1);
        end else if ((|strobe) && st_q.slot < FULL) begin
            st_d.we    = 1'b1;
            st_d.waddr = {cyc_lo, st_q.slot[EV_SW-1:0]};
            st_d.wdata = entry;
            st_d.slot  = st_q.slot + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign we    = st_q.we;
    assign waddr = st_q.waddr;
    assign wdata = st_q.wdata;

    p_slot0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> we && waddr[EV_SW-1:0] == '0);
    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && st_q.slot == FULL) |=> !we);
    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe == '0) |=> !we);
endmodule

// File: rtl/cycle_event_recorder.sv
module cycle_event_recorder
    import cer_pkg::*;
#(
    parameter int CYC_W     = 32,
    parameter int TIME_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int TT_DEPTH  = 4096,
    parameter int PTR_W     = 24,
    parameter int EV_CYCLES = 4,
    parameter int EV_SLOTS  = 16,
    localparam int TT_AW    = $clog2(TT_DEPTH),
    localparam int EV_AW    = $clog2(EV_CYCLES) + $clog2(EV_SLOTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_EVT-1:0]        evt_strobe,
    input  logic                    ms_tick,
    input  logic [ADDR_W-1:0]       data_wr_addr,
    output logic                    tt_we,
    output logic [TT_AW-1:0]        tt_waddr,
    output logic [ADDR_W+CYC_W-1:0] tt_wdata,
    output logic                    ev_we,
    output logic [EV_AW-1:0]        ev_waddr,
    output logic [CODE_W+PTR_W-1:0] ev_wdata,
    output logic [CYC_W-1:0]        cycle_num,
    output logic [TIME_W-1:0]       ms_time,
    output logic [TT_AW-1:0]        tt_last_addr
);
    logic             start;
    logic [CYC_W-1:0] cycle_next;
    logic [TT_AW-1:0] tt_ptr;

    assign start = evt_strobe[B_CYC_START];

    cer_cycle_clock #(.CYC_W(CYC_W), .TIME_W(TIME_W)) u_clock (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(ms_tick),
        .cycle_next(cycle_next), .cycle_q(cycle_num), .ms_q(ms_time)
    );

    cer_timing_writer #(.CYC_W(CYC_W), .ADDR_W(ADDR_W), .TT_DEPTH(TT_DEPTH)) u_timing (
        .clk(clk), .rst_n(rst_n), .tick(ms_tick), .data_addr(data_wr_addr),
        .cycle_next(cycle_next), .ptr_q(tt_ptr), .we(tt_we), .waddr(tt_waddr),
        .wdata(tt_wdata), .last(tt_last_addr)
    );

    cer_event_logger #(
        .N_EVT(N_EVT), .CODE_W(CODE_W), .PTR_W(PTR_W), .TT_AW(TT_AW),
        .EV_CYCLES(EV_CYCLES), .EV_SLOTS(EV_SLOTS)
    ) u_events (
        .clk(clk), .rst_n(rst_n), .strobe(evt_strobe), .start(start),
        .cyc_lo(cycle_next[$clog2(EV_CYCLES)-1:0]), .tt_ptr(tt_ptr),
        .we(ev_we), .waddr(ev_waddr), .wdata(ev_wdata)
    );

    p_last_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tt_we |-> tt_last_addr == tt_waddr);
endmodule

// File: tb/cycle_event_recorder_bench.sv
module cycle_event_recorder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_strobe = '0;
    logic        ms_tick = 1'b0;
    logic [31:0] data_wr_addr = '0;
    logic        tt_we, ev_we;
    logic [11:0] tt_waddr, tt_last_addr;
    logic [63:0] tt_wdata;
    logic [5:0]  ev_waddr;
    logic [31:0] ev_wdata, cycle_num, ms_time;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state
    int unsigned m_cycle = 0, m_ms = 0, m_ptr = 0, m_last = 0, m_slot = 0;

    always #4 clk = ~clk;

    cycle_event_recorder u_cycle_event_recorder (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .ms_tick(ms_tick),
        .data_wr_addr(data_wr_addr), .tt_we(tt_we), .tt_waddr(tt_waddr),
        .tt_wdata(tt_wdata), .ev_we(ev_we), .ev_waddr(ev_waddr),
        .ev_wdata(ev_wdata), .cycle_num(cycle_num), .ms_time(ms_time),
        .tt_last_addr(tt_last_addr)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one clock of stimulus and check every output afterwards
    task automatic step(logic [5:0] s, logic t, logic [31:0] a);
        bit st, e_we;
        int unsigned e_ea, e_ed, slot_used;
        @(negedge clk);
        evt_strobe = s; ms_tick = t; data_wr_addr = a;
        st = s[0];
        if (st) begin m_cycle++; m_ms = 0; end
        else if (t) m_ms++;
        e_we = 0;
        slot_used = 0;
        if (st) begin e_we = 1; slot_used = 0; m_slot = 1; end
        else if (s != 0 && m_slot < 16) begin e_we = 1; slot_used = m_slot; m_slot++; end
        e_ea = ((m_cycle & 3) << 4) | slot_used;
        e_ed = (32'(s) << 24) | m_ptr;
        @(negedge clk);
        evt_strobe = '0; ms_tick = 1'b0;
        chk("R2 cycle_num", cycle_num, m_cycle);
        chk("R3 ms_time", ms_time, m_ms);
        chk("R4 tt_we", tt_we, t);
        if (t) begin
            chk("R4 tt_wdata", tt_wdata, {a, m_cycle});
            chk("R5 tt_waddr", tt_waddr, m_ptr);
            m_last = m_ptr;
            m_ptr = (m_ptr + 1) % 4096;
        end
        chk("R6 tt_last_addr", tt_last_addr, m_last);
        chk("R9 ev_we", ev_we, e_we);
        if (e_we) begin
            chk("R7 ev_wdata", ev_wdata, e_ed);
            chk("R8 ev_waddr", ev_waddr, e_ea);
        end
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tt_we", tt_we, 0);
        chk("R1 ev_we", ev_we, 0);
        chk("R1 cycle_num", cycle_num, 0);
        chk("R1 ms_time", ms_time, 0);
        chk("R1 tt_last_addr", tt_last_addr, 0);
        chk("R1 tt_waddr", tt_waddr, 0);
    endtask

    task automatic t_counting_r2_r3();
        step(6'h01, 0, 32'h0);
        for (int i = 0; i < 5; i++) step(6'h00, 1, 32'h1000 + i);
        step(6'h00, 0, 32'h0);
        step(6'h01, 0, 32'h0);
        for (int i = 0; i < 3; i++) step(6'h00, 1, 32'hA000 + i);
    endtask

    task automatic t_start_with_tick_r3_r4();
        step(6'h01, 1, 32'hDEAD_BEEF);
        step(6'h00, 1, 32'h1234_5678);
    endtask

    task automatic t_event_codes_r7_r8();
        step(6'h01, 0, 32'h0);
        step(6'h04, 0, 32'h0);
        step(6'h08, 1, 32'h55);
        step(6'h30, 0, 32'h0);
        step(6'h02, 1, 32'h66);
        step(6'h00, 1, 32'h77);
    endtask

    task automatic t_overflow_r9();
        step(6'h01, 0, 32'h0);
        for (int i = 0; i < 20; i++) step(6'h10, i[0], 32'(i));
        step(6'h01, 0, 32'h0);
        step(6'h20, 0, 32'h0);
    endtask

    task automatic t_region_reuse_r10();
        int unsigned base;
        for (int c = 0; c < 5; c++) begin
            step(6'h01, 0, 32'h0);
            base = (m_cycle & 3) << 4;
            chk("R10 region", ev_waddr, base);
            step(6'h02, 0, 32'h0);
            chk("R10 slot1", ev_waddr, base | 1);
        end
    endtask

    task automatic t_wrap_r5_r6();
        for (int i = 0; i < 4100; i++) step(6'h00, 1, 32'(i * 8));
        chk("R5 wrapped", tt_waddr, (m_ptr + 4095) % 4096);
        step(6'h04, 0, 32'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset_r1();
        t_counting_r2_r3();
        t_start_with_tick_r3_r4();
        t_event_codes_r7_r8();
        t_overflow_r9();
        t_region_reuse_r10();
        t_wrap_r5_r6();
        finish_run();
    end
endmodule